// File: doc/BRIEF.md
# AES-128 Encryption Round Unit

This block carries out one round of the AES-128 cipher on a 128-bit state. Four transforms run in a fixed order: byte substitution, row rotation, column mixing and round-key addition. Each transform has its own enable pin, so one unit serves every round type. With only the key addition enabled it does the initial whitening step. With all four enabled it does rounds 1 to 9. With column mixing off it does the last round. A controller outside the block supplies the round keys and counts the rounds.

A one-cycle `start` strobe loads the state, the round key and the enables. The sixteen byte substitutions are looked up one per byte, each with a registered output, so the result appears one clock after `start`, together with a one-cycle `out_valid` pulse. There is no back-pressure. The consumer must accept the result in the cycle `out_valid` is high. The result then stays on `state_out` until the next `start`, so a slow consumer can still read it later. `start` may be held high on consecutive cycles, and each such cycle produces a result one cycle later.

Top module: `aes_round_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `start`, `out_valid` is 0 and `state_out` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `start` is 1, and 0 otherwise. Starts on consecutive cycles give results on consecutive cycles.
- R3: With `en_sub` set, every state byte is replaced by its AES S-box value, for example 00→63, 53→ed and ff→16.
- R4: Byte k of the state is bits [127-8k -: 8] and sits at row k mod 4, column k div 4. With `en_shift` set, row r is rotated left by r columns with wrap-around, and row 0 stays unchanged.
- R5: With `en_mix` set, each column (b0..b3, b0 in the top row) is multiplied by the circulant matrix {02 03 01 01} over GF(2^8). Doubling is a left shift followed by XOR with 1b when the bit shifted out is 1. For example, column db 13 53 45 becomes 8e 4d a1 bc.
- R6: With `en_key` set, key word j (bits [127-32j -: 32] of `rkey_in`) is XORed into column j of the state.
- R7: The enabled transforms apply in the order substitution, rotation, mixing, key addition. With all four enabled the unit gives a full middle round. With every enable except `en_mix` it gives the final round.
- R8: With all four enables low, `state_out` equals the `state_in` captured at `start`.
- R9: Without `start`, `state_out` holds its last value. Changes on `state_in`, `rkey_in` or the enables have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the inputs and begin one round |
| en_sub | input | 1 | Enable byte substitution |
| en_shift | input | 1 | Enable row rotation |
| en_mix | input | 1 | Enable column mixing |
| en_key | input | 1 | Enable round-key addition |
| state_in | input | 128 | State to transform, byte 0 in the top bits |
| rkey_in | input | 128 | Round key, word 0 in the top bits |
| state_out | output | 128 | Transformed state, held until the next start |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result is due one rising edge after the `start` that requested it. No other register lies between the inputs and `state_out`, so the result and `out_valid` appear together at that edge. The bench drives each start on a falling edge and reads `out_valid` and `state_out` on the next falling edge, half a period after the result edge. Checks of the hold and single-pulse behaviour read the outputs on one or more later falling edges, in cycles with no start pending.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  typedef logic [7:0] byte_t;

  function automatic byte_t gf_dbl(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p;
    byte_t x;
    byte_t y;
    p = 8'h00;
    x = a;
    y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = gf_dbl(x);
      y = {1'b0, y[7:1]};
    end
    return p;
  endfunction

  function automatic byte_t rotl8(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (8 - n)));
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic byte_t sbox_of(input byte_t x);
    byte_t r;
    byte_t b;
    logic [7:0] e;
    r = 8'h01;
    b = x;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, b);
      b = gf_mul(b, b);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    byte_t b0, b1, b2, b3;
    byte_t o0, o1, o2, o3;
    b0 = c[31:24];
    b1 = c[23:16];
    b2 = c[15:8];
    b3 = c[7:0];
    o0 = gf_dbl(b0) ^ gf_dbl(b1) ^ b1 ^ b2 ^ b3;
    o1 = b0 ^ gf_dbl(b1) ^ gf_dbl(b2) ^ b2 ^ b3;
    o2 = b0 ^ b1 ^ gf_dbl(b2) ^ gf_dbl(b3) ^ b3;
    o3 = gf_dbl(b0) ^ b0 ^ b1 ^ b2 ^ gf_dbl(b3);
    return {o0, o1, o2, o3};
  endfunction

endpackage

// File: rtl/aes_sbox_cell.sv
module aes_sbox_cell
  import aes_rnd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  bypass,
  input  byte_t din,
  output byte_t dout
);

  byte_t lut_val;

  assign lut_val = sbox_of(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 8'h00;
    end else if (load) begin
      dout <= bypass ? din : lut_val;
    end
  end

endmodule

// File: rtl/aes_row_shift.sv
module aes_row_shift #(
  parameter int NROW = 4,
  parameter int NCOL = 4
) (
  input  logic                     en,
  input  logic [8*NROW*NCOL-1:0]   din,
  output logic [8*NROW*NCOL-1:0]   dout
);

  localparam int W = 8 * NROW * NCOL;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      localparam int DST = NROW * c + r;
      localparam int SRC = NROW * ((c + r) % NCOL) + r;
      assign dout[W-1-8*DST -: 8] = en ? din[W-1-8*SRC -: 8] : din[W-1-8*DST -: 8];
    end
  end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
  import aes_rnd_pkg::*;
#(
  parameter int NCOL = 4
) (
  input  logic                en,
  input  logic [32*NCOL-1:0]  din,
  output logic [32*NCOL-1:0]  dout
);

  localparam int W = 32 * NCOL;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [31:0] col_in;
    assign col_in = din[W-1-32*c -: 32];
    assign dout[W-1-32*c -: 32] = en ? mix_col(col_in) : col_in;
  end

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit #(
  parameter int NROW = 4,
  parameter int NCOL = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   en_sub,
  input  logic                   en_shift,
  input  logic                   en_mix,
  input  logic                   en_key,
  input  logic [8*NROW*NCOL-1:0] state_in,
  input  logic [8*NROW*NCOL-1:0] rkey_in,
  output logic [8*NROW*NCOL-1:0] state_out,
  output logic                   out_valid
);

  localparam int NB  = NROW * NCOL;
  localparam int STW = 8 * NB;

  logic           shift_q;
  logic           mix_q;
  logic           key_q;
  logic [STW-1:0] rkey_q;
  logic [STW-1:0] sub_q;
  logic [STW-1:0] shifted;
  logic [STW-1:0] mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      shift_q   <= 1'b0;
      mix_q     <= 1'b0;
      key_q     <= 1'b0;
      rkey_q    <= '0;
    end else begin
      out_valid <= start;
      if (start) begin
        shift_q <= en_shift;
        mix_q   <= en_mix;
        key_q   <= en_key;
        rkey_q  <= rkey_in;
      end
    end
  end

  // one registered lookup per state byte
  for (genvar k = 0; k < NB; k++) begin : g_sbox
    aes_sbox_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .bypass (!en_sub),
      .din    (state_in[STW-1-8*k -: 8]),
      .dout   (sub_q[STW-1-8*k -: 8])
    );
  end

  aes_row_shift #(.NROW(NROW), .NCOL(NCOL)) u_shift (
    .en   (shift_q),
    .din  (sub_q),
    .dout (shifted)
  );

  aes_col_mix #(.NCOL(NCOL)) u_mix (
    .en   (mix_q),
    .din  (shifted),
    .dout (mixed)
  );

  assign state_out = key_q ? (mixed ^ rkey_q) : mixed;

endmodule

// File: rtl/aes_round_chk.sv
module aes_round_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         en_sub,
  input logic         en_shift,
  input logic         en_mix,
  input logic         en_key,
  input logic [W-1:0] state_in,
  input logic [W-1:0] rkey_in,
  input logic [W-1:0] state_out,
  input logic         out_valid
);

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);

  a_r9_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(state_out));

  a_r8_all_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !en_sub && !en_shift && !en_mix && !en_key) |=> (state_out == $past(state_in)));

  a_r6_key_only_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !en_sub && !en_shift && !en_mix && en_key) |=> (state_out == $past(state_in ^ rkey_in)));

endmodule

bind aes_round_unit aes_round_chk #(.W(STW)) u_chk (.*);

// File: tb/sim_aes_round_unit.sv
module sim_aes_round_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         en_sub, en_shift, en_mix, en_key;
  logic [127:0] state_in, rkey_in;
  logic [127:0] state_out;
  logic         out_valid;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  aes_round_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .en_sub(en_sub), .en_shift(en_shift), .en_mix(en_mix), .en_key(en_key),
    .state_in(state_in), .rkey_in(rkey_in),
    .state_out(state_out), .out_valid(out_valid)
  );

  // en = {sub, shift, mix, key}
  typedef struct packed {
    logic [3:0]   req;
    logic [3:0]   en;
    logic [127:0] st;
    logic [127:0] key;
    logic [127:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R6 key addition only
    '{4'd6, 4'b0001, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h193de3bea0f4e22b9ac68d2ae9f84808},
    // R3 substitution only
    '{4'd3, 4'b1000, 128'h193de3bea0f4e22b9ac68d2ae9f84808, 128'h0, 128'hd42711aee0bf98f1b8b45de51e415230},
    // R4 rotation only
    '{4'd4, 4'b0100, 128'hd42711aee0bf98f1b8b45de51e415230, 128'h0, 128'hd4bf5d30e0b452aeb84111f11e2798e5},
    // R5 mixing only
    '{4'd5, 4'b0010, 128'hd4bf5d30e0b452aeb84111f11e2798e5, 128'h0, 128'h046681e5e0cb199a48f8d37a2806264c},
    // R7 full middle round
    '{4'd7, 4'b1111, 128'h193de3bea0f4e22b9ac68d2ae9f84808, 128'ha0fafe1788542cb123a339392a6c7605, 128'ha49c7ff2689f352b6b5bea43026a5049},
    // R7 final round, no mixing
    '{4'd7, 4'b1101, 128'h193de3bea0f4e22b9ac68d2ae9f84808, 128'ha0fafe1788542cb123a339392a6c7605, 128'h7445a32768e07e1f9be228c8344beee0},
    // R8 all enables off, key ignored
    '{4'd8, 4'b0000, 128'h0123456789abcdeffedcba9876543210, {128{1'b1}}, 128'h0123456789abcdeffedcba9876543210},
    // R3 corner bytes
    '{4'd3, 4'b1000, 128'h0, 128'h0, {16{8'h63}}},
    '{4'd3, 4'b1000, {16{8'hff}}, 128'h0, {16{8'h16}}},
    '{4'd3, 4'b1000, {16{8'h53}}, 128'h0, {16{8'hed}}},
    // R5 single-column example and identity column
    '{4'd5, 4'b0010, {4{32'hdb135345}}, 128'h0, {4{32'h8e4da1bc}}},
    '{4'd5, 4'b0010, {16{8'h01}}, 128'h0, {16{8'h01}}},
    // R4 distinct bytes expose the layout
    '{4'd4, 4'b0100, 128'h000102030405060708090a0b0c0d0e0f, 128'h0, 128'h00050a0f04090e03080d02070c01060b}
  };

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_st(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    {en_sub, en_shift, en_mix, en_key} = 4'b1111;
    state_in = {16{8'h5a}};
    rkey_in  = {16{8'ha5}};
    repeat (3) @(negedge clk);
    // R1 outputs cleared while in reset
    chk_bit("R1 valid in reset", out_valid, 1'b0);
    chk_st("R1 state in reset", state_out, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_bit("R1 valid after reset", out_valid, 1'b0);
    chk_st("R1 state after reset", state_out, 128'h0);

    // vector table, starts back to back (R2)
    for (int i = 0; i < NV; i++) begin
      {en_sub, en_shift, en_mix, en_key} = VECS[i].en;
      state_in = VECS[i].st;
      rkey_in  = VECS[i].key;
      start    = 1'b1;
      @(negedge clk);
      chk_bit("R2 valid one cycle after start", out_valid, 1'b1);
      chk_st($sformatf("R%0d vector %0d", VECS[i].req, i), state_out, VECS[i].exp);
    end
    start = 1'b0;
    @(negedge clk);
    chk_bit("R2 valid drops without start", out_valid, 1'b0);

    // R9 input changes without start are ignored
    {en_sub, en_shift, en_mix, en_key} = 4'b1111;
    state_in = {16{8'hc3}};
    rkey_in  = {16{8'h3c}};
    repeat (3) @(negedge clk);
    chk_st("R9 state held", state_out, VECS[NV-1].exp);
    chk_bit("R9 no valid while idle", out_valid, 1'b0);

    // R2 single start then idle gap
    {en_sub, en_shift, en_mix, en_key} = 4'b0000;
    state_in = 128'hfeedfacecafebeef0011223344556677;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_bit("R2 pulse high", out_valid, 1'b1);
    chk_st("R8 pass-through", state_out, 128'hfeedfacecafebeef0011223344556677);
    @(negedge clk);
    chk_bit("R2 pulse is one cycle", out_valid, 1'b0);

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R1 valid on reset", out_valid, 1'b0);
    chk_st("R1 state on reset", state_out, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule